// File: doc/BRIEF.md
# Conversion Result Bank with Automatic Compare

This block sits between an analog-to-digital converter sequencer and a CPU register port. It keeps ten 16-bit slots, one for each conversion position within a sequence (position 0 to 9, not the analog channel number). When the converter finishes a conversion, it delivers a 12-bit unsigned result, the conversion's position and a one-cycle done strobe.

Each slot works in one of two ways. As a plain result slot, the block stores the result there in right- or left-justified form, as a mode bit selects. As a compare slot, the slot holds a threshold that the CPU has written. The block then throws the result away and sets a sticky status flag for that position when the result meets the slot's chosen relation to the threshold.

A write to the compare-direction register raises a one-cycle abort pulse toward the sequencer. All registers can be read and written at any time. A read returns its value in the same cycle, with no extra wait.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every slot, the compare-enable mask, the direction mask, the status flags and the mode bit read as zero, and `seq_abort` is low.
- R2: With the mode bit (address 13, bit 0) at 0, a conversion at position n whose enable bit is clear stores `{4'b0, result}` in slot n (address n). The new value can be read in the cycle after the strobe.
- R3: With the mode bit at 1, such a conversion stores `{result, 4'b0}` in slot n.
- R4: When bit n of the compare-enable mask (address 10) is set, a conversion at position n leaves slot n unchanged.
- R5: For a compare conversion, the threshold is slot bits 11:0 when the mode bit is 0 and slot bits 15:4 when it is 1. The relation depends on bit n of the direction mask (address 11). When that bit is 1, flag n is set if the result is strictly greater than the threshold. When it is 0, flag n is set if the result is less than or equal to the threshold.
- R6: The status flags (address 12, bit n for position n) are sticky. Writing 1 to a bit clears it. If a compare sets a flag in the same cycle as a write-1 clears it, the flag stays set.
- R7: Any CPU write to address 11 drives `seq_abort` high for exactly the one cycle after the write. No other access raises it.
- R8: Bits 15:10 of addresses 10, 11 and 12, and bits 15:1 of address 13, read as zero. Addresses 14 and 15 read as zero, and writes to them change nothing.
- R9: A strobe whose position is 10 to 15 changes no slot and no flag.
- R10: If a CPU write to slot n and a storing conversion at position n fall in the same cycle, the slot takes the conversion value.
- R11: The CPU can write a slot at any time and read back all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle conversion-done strobe |
| conv_index | input | 4 | Position of the conversion within the sequence |
| conv_data | input | 12 | Unsigned conversion result |
| cpu_wr | input | 1 | CPU write enable for this cycle |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr`, valid in the same cycle |
| seq_abort | output | 1 | One-cycle abort request to the sequencer |

## Verification
The block takes a strobe or a CPU write on a rising edge. The new slot value and flag value can then be read through the combinational read port in the cycle that edge opens. `seq_abort` is high during that same following cycle.

The bench changes its inputs on the falling edge and lets one rising edge pass. It then compares `seq_abort` at the next falling edge, and reads back through `cpu_addr` one nanosecond later, still before the next rising edge. Its reference model is updated only from the inputs applied at that rising edge, using the register values from before the edge. This lets it reproduce same-cycle cases such as a compare against the old threshold and a conversion winning a slot conflict.

// File: rtl/adcbank_pkg.sv
package adcbank_pkg;

  typedef enum logic [2:0] {
    K_SLOT,
    K_EN,
    K_DIR,
    K_FLAG,
    K_MODE,
    K_NONE
  } reg_kind_e;

  // Slots occupy the low addresses; control registers follow directly.
  function automatic reg_kind_e decode_addr(input int addr, input int nslots);
    if (addr < nslots)             return K_SLOT;
    else if (addr == nslots)       return K_EN;
    else if (addr == nslots + 1)   return K_DIR;
    else if (addr == nslots + 2)   return K_FLAG;
    else if (addr == nslots + 3)   return K_MODE;
    else                           return K_NONE;
  endfunction

endpackage

// File: rtl/adcbank_format.sv
// Places a raw result into register layout and pulls a threshold back out,
// both according to the justification mode.
module adcbank_format #(
  parameter int RES_W = 12,
  parameter int REG_W = 16
) (
  input  logic [RES_W-1:0] res,
  input  logic [REG_W-1:0] slot_val,
  input  logic             left,
  output logic [REG_W-1:0] packed_val,
  output logic [RES_W-1:0] thr
);

  localparam int PAD = REG_W - RES_W;

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        packed_val = left ? {res, {PAD{1'b0}}} : {{PAD{1'b0}}, res};
        thr        = left ? slot_val[REG_W-1 -: RES_W] : slot_val[RES_W-1:0];
      end
    end else begin : g_nopad
      logic unused_left;
      always_comb begin
        unused_left = left;
        packed_val  = res;
        thr         = slot_val;
      end
    end
  endgenerate

endmodule

// File: rtl/adcbank_slots.sv
// Per-slot storage. A storing conversion wins over a CPU write in one cycle.
module adcbank_slots #(
  parameter int NUM_SLOTS = 10,
  parameter int REG_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] conv_we,
  input  logic [NUM_SLOTS-1:0] cpu_we,
  input  logic [REG_W-1:0]     conv_val,
  input  logic [REG_W-1:0]     cpu_val,
  output logic [REG_W-1:0]     slot_q [NUM_SLOTS]
);

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [REG_W-1:0] d;
      logic             en;

      always_comb begin
        en = conv_we[i] | cpu_we[i];
        d  = conv_we[i] ? conv_val : cpu_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  slot_q[i] <= '0;
        else if (en) slot_q[i] <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/adcbank_cmpflags.sv
// Threshold comparison and sticky per-position status flags.
module adcbank_cmpflags #(
  parameter int NUM_SLOTS = 10,
  parameter int RES_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] cmp_fire,
  input  logic [RES_W-1:0]     res,
  input  logic [RES_W-1:0]     thr,
  input  logic                 above,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic [NUM_SLOTS-1:0] flag_q
);

  logic                 hit;
  logic [NUM_SLOTS-1:0] set_mask;
  logic [NUM_SLOTS-1:0] flag_d;
  logic                 flag_en;

  always_comb begin
    hit      = above ? (res > thr) : (res <= thr);
    set_mask = cmp_fire & {NUM_SLOTS{hit}};
    flag_d   = (flag_q & ~clr_mask) | set_mask;
    flag_en  = (|clr_mask) | (|set_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adcbank_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int RES_W     = 12,
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [IDX_W-1:0]  conv_index,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              seq_abort
);

  localparam int MASK_PAD = REG_W - NUM_SLOTS;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Address decode
  reg_kind_e kind;
  always_comb kind = decode_addr(int'(cpu_addr), NUM_SLOTS);

  // Control registers
  logic [NUM_SLOTS-1:0] cmp_en_q,  cmp_en_d;
  logic [NUM_SLOTS-1:0] cmp_dir_q, cmp_dir_d;
  logic                 mode_q,    mode_d;
  logic                 en_we, dir_we, mode_we;
  logic                 abort_q,   abort_d;

  always_comb begin
    en_we     = cpu_wr && (kind == K_EN);
    dir_we    = cpu_wr && (kind == K_DIR);
    mode_we   = cpu_wr && (kind == K_MODE);
    cmp_en_d  = cpu_wdata[NUM_SLOTS-1:0];
    cmp_dir_d = cpu_wdata[NUM_SLOTS-1:0];
    mode_d    = cpu_wdata[0];
    abort_d   = dir_we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_en_q  <= '0;
      cmp_dir_q <= '0;
      mode_q    <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      if (en_we)   cmp_en_q  <= cmp_en_d;
      if (dir_we)  cmp_dir_q <= cmp_dir_d;
      if (mode_we) mode_q    <= mode_d;
      abort_q <= abort_d;
    end
  end

  assign seq_abort = abort_q;

  // Conversion steering
  logic                 conv_ok;
  logic [NUM_SLOTS-1:0] conv_sel, store_we, cmp_fire, cpu_slot_we, flag_clr;
  logic [REG_W-1:0]     slot_q [NUM_SLOTS];
  logic [REG_W-1:0]     sel_slot;
  logic                 sel_above;

  always_comb conv_ok = conv_valid && (conv_index < IDX_W'(NUM_SLOTS));

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
      always_comb begin
        conv_sel[i]    = conv_ok && (conv_index == IDX_W'(i));
        cpu_slot_we[i] = cpu_wr && (cpu_addr == ADDR_W'(i));
      end
    end
  endgenerate

  always_comb begin
    store_we  = conv_sel & ~cmp_en_q;
    cmp_fire  = conv_sel & cmp_en_q;
    sel_above = |(conv_sel & cmp_dir_q);
    flag_clr  = (cpu_wr && (kind == K_FLAG)) ? cpu_wdata[NUM_SLOTS-1:0] : '0;
    sel_slot  = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      sel_slot = sel_slot | (slot_q[i] & {REG_W{conv_sel[i]}});
  end

  // Datapath
  logic [REG_W-1:0] conv_packed;
  logic [RES_W-1:0] sel_thr;
  logic [NUM_SLOTS-1:0] flag_q;

  adcbank_format #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
    .res        (conv_data),
    .slot_val   (sel_slot),
    .left       (mode_q),
    .packed_val (conv_packed),
    .thr        (sel_thr)
  );

  adcbank_slots #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .conv_we  (store_we),
    .cpu_we   (cpu_slot_we),
    .conv_val (conv_packed),
    .cpu_val  (cpu_wdata),
    .slot_q   (slot_q)
  );

  adcbank_cmpflags #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmp_fire (cmp_fire),
    .res      (conv_data),
    .thr      (sel_thr),
    .above    (sel_above),
    .clr_mask (flag_clr),
    .flag_q   (flag_q)
  );

  // Read port
  always_comb begin
    cpu_rdata = '0;
    unique case (kind)
      K_SLOT: begin
        for (int i = 0; i < NUM_SLOTS; i++)
          if (cpu_addr == ADDR_W'(i)) cpu_rdata = slot_q[i];
      end
      K_EN:    cpu_rdata = {{MASK_PAD{1'b0}}, cmp_en_q};
      K_DIR:   cpu_rdata = {{MASK_PAD{1'b0}}, cmp_dir_q};
      K_FLAG:  cpu_rdata = {{MASK_PAD{1'b0}}, flag_q};
      K_MODE:  cpu_rdata = {{(REG_W-1){1'b0}}, mode_q};
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adcbank_checker.sv
module adcbank_checker #(
  parameter int NUM_SLOTS = 10,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_wr,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic                 conv_valid,
  input logic [IDX_W-1:0]     conv_index,
  input logic                 seq_abort,
  input logic [NUM_SLOTS-1:0] flag_q
);

  localparam int ADDR_DIR  = NUM_SLOTS + 1;
  localparam int ADDR_FLAG = NUM_SLOTS + 2;

  logic dir_wr, flag_wr, conv_in_range;
  always_comb begin
    dir_wr        = cpu_wr && (cpu_addr == ADDR_W'(ADDR_DIR));
    flag_wr       = cpu_wr && (cpu_addr == ADDR_W'(ADDR_FLAG));
    conv_in_range = conv_valid && (conv_index < IDX_W'(NUM_SLOTS));
  end

  a_r7_abort_follows_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> seq_abort);

  a_r7_abort_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> $past(dir_wr));

  a_r6_flags_only_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r9_no_new_flag_without_valid_conv: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_in_range |=> ((flag_q & ~$past(flag_q)) == '0));

  a_r5_at_most_one_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    conv_in_range |=> ($countones(flag_q & ~$past(flag_q)) <= 1));

endmodule

bind adc_result_bank adcbank_checker #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .conv_valid (conv_valid),
  .conv_index (conv_index),
  .seq_abort  (seq_abort),
  .flag_q     (flag_q)
);

// File: tb/adc_result_bank_test.sv
`timescale 1ns/1ps
module adc_result_bank_test;

  logic        clk;
  logic        rst_n;
  logic        conv_valid;
  logic [3:0]  conv_index;
  logic [11:0] conv_data;
  logic        cpu_wr;
  logic [3:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        seq_abort;

  adc_result_bank uut (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_index(conv_index),
    .conv_data(conv_data), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .seq_abort(seq_abort)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // Reference model
  logic [15:0] m_slot [10];
  logic [9:0]  m_en, m_dir, m_flag;
  logic        m_mode, m_abort;

  function automatic logic [15:0] pack(input logic [11:0] r, input logic left);
    return left ? {r, 4'h0} : {4'h0, r};
  endfunction

  function automatic logic [11:0] thr_of(input logic [15:0] s, input logic left);
    return left ? s[15:4] : s[11:0];
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    if (a < 4'd10)       return m_slot[a];
    else if (a == 4'd10) return {6'h0, m_en};
    else if (a == 4'd11) return {6'h0, m_dir};
    else if (a == 4'd12) return {6'h0, m_flag};
    else if (a == 4'd13) return {15'h0, m_mode};
    else                 return 16'h0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 10; i++) m_slot[i] = 16'h0;
    m_en = '0; m_dir = '0; m_flag = '0; m_mode = 1'b0; m_abort = 1'b0;
  endtask

  task automatic m_step(input logic wr, input logic [3:0] a, input logic [15:0] wd,
                        input logic cv, input logic [3:0] ix, input logic [11:0] d);
    logic [9:0]  setm, clr;
    logic        store;
    logic [15:0] pv;
    logic [11:0] t;
    setm  = '0;
    clr   = '0;
    store = 1'b0;
    pv    = pack(d, m_mode);
    if (cv && ix < 4'd10) begin
      if (m_en[ix]) begin
        t = thr_of(m_slot[ix], m_mode);
        if (m_dir[ix] ? (d > t) : (d <= t)) setm[ix] = 1'b1;
      end else begin
        store = 1'b1;
      end
    end
    m_abort = wr && (a == 4'd11);
    if (wr) begin
      if (a < 4'd10)       m_slot[a] = wd;
      else if (a == 4'd10) m_en   = wd[9:0];
      else if (a == 4'd11) m_dir  = wd[9:0];
      else if (a == 4'd12) clr    = wd[9:0];
      else if (a == 4'd13) m_mode = wd[0];
    end
    if (store) m_slot[ix] = pv;
    m_flag = (m_flag & ~clr) | setm;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [15:0] wd,
                     input logic cv, input logic [3:0] ix, input logic [11:0] d);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    conv_valid = cv; conv_index = ix; conv_data = d;
    @(posedge clk);
    m_step(wr, a, wd, cv, ix, d);
    @(negedge clk);
    cpu_wr = 1'b0; conv_valid = 1'b0;
    chk("R7 seq_abort", {15'h0, seq_abort}, {15'h0, m_abort});
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] wd);
    cyc(1'b1, a, wd, 1'b0, 4'h0, 12'h0);
  endtask

  task automatic conv(input logic [3:0] ix, input logic [11:0] d);
    cyc(1'b0, 4'h0, 16'h0, 1'b1, ix, d);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cpu_wr = 1'b0; cpu_addr = a;
    #1;
    chk(tag, cpu_rdata, m_read(a));
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [15:0] exp, input string tag);
    cpu_wr = 1'b0; cpu_addr = a;
    #1;
    chk(tag, cpu_rdata, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    conv_valid = 1'b0; conv_index = '0; conv_data = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 16; a++) rd_exp(4'(a), 16'h0, "R1 reset value");
    chk("R1 abort after reset", {15'h0, seq_abort}, 16'h0);

    // R2: right justified store
    conv(4'd3, 12'hABC);
    rd_exp(4'd3, 16'h0ABC, "R2 right justify");
    // R3: left justified store
    wr_reg(4'd13, 16'hFFFF);
    rd_exp(4'd13, 16'h0001, "R8 mode upper bits");
    conv(4'd9, 12'h123);
    rd_exp(4'd9, 16'h1230, "R3 left justify");
    // R11: CPU slot write
    wr_reg(4'd5, 16'hBEEF);
    rd_exp(4'd5, 16'hBEEF, "R11 slot readback");

    // R4/R5: compare, direction above, left mode, threshold 0x800
    wr_reg(4'd10, 16'h0004);
    wr_reg(4'd11, 16'h0004);
    chk("R7 abort after dir write", {15'h0, seq_abort}, 16'h1);
    wr_reg(4'd2, 16'h8000);
    conv(4'd2, 12'h800);
    rd_exp(4'd2, 16'h8000, "R4 slot kept");
    rd_exp(4'd12, 16'h0000, "R5 equal not above");
    conv(4'd2, 12'h801);
    rd_exp(4'd12, 16'h0004, "R5 above sets");
    conv(4'd2, 12'h100);
    rd_exp(4'd12, 16'h0004, "R6 sticky");
    wr_reg(4'd12, 16'h0004);
    rd_exp(4'd12, 16'h0000, "R6 write one clears");
    // direction lower-or-same
    wr_reg(4'd11, 16'h0000);
    conv(4'd2, 12'h801);
    rd_exp(4'd12, 16'h0000, "R5 above not low");
    conv(4'd2, 12'h800);
    rd_exp(4'd12, 16'h0004, "R5 equal is low-or-same");
    // R6: simultaneous set and clear
    cyc(1'b1, 4'd12, 16'h0004, 1'b1, 4'd2, 12'h010);
    rd_exp(4'd12, 16'h0004, "R6 set beats clear");
    wr_reg(4'd12, 16'h03FF);

    // R9: out-of-range positions
    wr_reg(4'd13, 16'h0000);
    for (int ix = 10; ix < 16; ix++) conv(4'(ix), 12'hFFF);
    for (int a = 0; a < 10; a++) rd(4'(a), "R9 slots untouched");
    rd_exp(4'd12, 16'h0000, "R9 flags untouched");

    // R10: conflict, conversion wins
    cyc(1'b1, 4'd7, 16'h1111, 1'b1, 4'd7, 12'h222);
    rd_exp(4'd7, 16'h0222, "R10 conversion wins");

    // R8: upper bits and unused addresses
    wr_reg(4'd10, 16'hFFFF);
    rd_exp(4'd10, 16'h03FF, "R8 enable upper bits");
    wr_reg(4'd14, 16'hFFFF);
    wr_reg(4'd15, 16'hFFFF);
    rd_exp(4'd14, 16'h0000, "R8 unused addr");
    for (int a = 0; a < 14; a++) rd(4'(a), "R8 unused write no effect");
    wr_reg(4'd10, 16'h0000);

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      logic        wr, cv;
      logic [3:0]  a, ix;
      logic [15:0] wd;
      wr = ($urandom_range(0, 2) == 0);
      cv = ($urandom_range(0, 1) == 0);
      a  = 4'($urandom_range(0, 15));
      ix = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
      wd = 16'($urandom);
      cyc(wr, a, wd, cv, ix, 12'($urandom));
      rd(4'($urandom_range(0, 15)), "R5 R2 R3 R6 random readback");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule